// File: doc/BRIEF.md
# Quadrature Waveform DAC Sequencer

This block is a serial master. It drives a four-channel, 16-bit-word serial DAC so that the DAC produces a two-phase test signal. Channels A and B carry a differential sine and channels C and D carry a differential cosine. A reload timer sets the sample rate, and each expiry of the timer starts one sample sequence.

Each sequence starts by pulsing the active-low update strobe. This makes the DAC latch the four codes that were sent in the previous sequence. The block then lowers the active-low select and sends four framed words, each with its own frame-sync pulse and with an idle gap after it. When the last gap ends, the block raises select and advances a 5-bit rolling phase pointer.

A single 32-entry sine table supplies all four channels. Each channel reads it at a fixed quarter-period offset from the pointer. If a timer expiry arrives while a sequence is still running, it is held and the next sequence starts as soon as the current one ends.

Top module: `qdac_seq`

## Requirements
- R1: While reset is held and after its release, before any timer expiry, the outputs rest at upd_n=1, sel_n=1, frm_n=1, ser_clk=0, ser_dat=0 and busy=0.
- R2: The timer fires every (1+major_len)×(1+minor_len) clocks, counted from reset release. After edge P (P being that period), the first strobe goes low on edge P+1. When the block is idle, strobes then start every P clocks.
- R3: The update strobe stays low for STROBE_CYC clocks. Select falls on the same edge on which the strobe rises, and select is never low while the strobe is low.
- R4: Select stays low across all four frames and their gaps. It rises after the fourth gap, having been low for 1+4×(32×SCLK_HALF+GAP_CYC) clocks.
- R5: Each word is sent MSB first as 16 bits: bits 15:14 hold the channel address (A=00, B=01, C=10, D=11), bit 13 is the power-down bit (always 0), bit 12 is the fast-speed bit (always 1), bits 11:2 hold the sample, and bits 1:0 are 0. This gives a top nibble of 0x1, 0x5, 0x9 or 0xD.
- R6: The words go out in the order A, C, B, D. Each word is framed by frm_n being low for exactly 16 ser_clk periods, and frm_n stays high for GAP_CYC clocks after each word. ser_clk is high only while frm_n is low.
- R7: Each bit period is SCLK_HALF clocks of ser_clk high followed by SCLK_HALF clocks low. ser_dat changes only when ser_clk rises or frm_n rises, so it is stable at every falling edge of ser_clk.
- R8: The sample for channel A is table[p], for C it is table[(p+8) mod 32], for B table[(p+16) mod 32] and for D table[(p+24) mod 32]. Here table[k] = round(512 + 511·sin(2πk/32)) and p is the pointer.
- R9: The pointer starts at 0, increases by 1 when select rises at the end of each sequence, and wraps from 31 to 0.
- R10: A timer expiry that arrives while busy is held. The next sequence then starts one clock after select rises, so that sequences run back to back. busy is high from the strobe's falling edge until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| major_len | input | PRD_W | Main timer reload; the period factor is major_len+1 |
| minor_len | input | DIV_W | Prescaler reload; the period factor is minor_len+1 |
| ser_clk | output | 1 | Serial clock to the DAC |
| ser_dat | output | 1 | Serial data, MSB first |
| frm_n | output | 1 | Active-low frame sync, one pulse per word |
| sel_n | output | 1 | Active-low device select |
| upd_n | output | 1 | Active-low update strobe for all DAC channels |
| busy | output | 1 | A sequence is in progress |

## Verification
If the phase pointer or the word slot were wrong, the wrong code would show on ser_dat within the first word that is affected. The sample field would no longer follow the quarter-offset sine pattern, or the address nibble would break the A, C, B, D order. If the sequencer's counters slipped, the edges of ser_clk, frm_n or sel_n would move by at least one clock. The edge-by-edge comparison against the model reports such a slip on that very cycle. If a timer expiry were lost or held wrongly, the next strobe would come late or early, and the spacing between strobes would differ by at least one period from either P or the back-to-back sequence length.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int TBL_AW   = 5;
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int SAMPLE_W = 10;
  localparam int WORD_W   = 16;
  localparam int NUM_CH   = 4;
  localparam int SLOT_W   = $clog2(NUM_CH);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_SETUP,
    ST_SHIFT,
    ST_GAP
  } seq_st_e;

  // Slot order on the wire is A, C, B, D; the channel address is the slot index bit-reversed.
  function automatic logic [WORD_W-1:0] make_word(input logic [SLOT_W-1:0] slot,
                                                  input logic [SAMPLE_W-1:0] smp);
    logic [1:0] chan;
    chan = {slot[0], slot[1]};
    return {chan, 1'b0, 1'b1, smp, 2'b00};
  endfunction
endpackage

// File: rtl/qdac_tick.sv
module qdac_tick #(
  parameter int PRD_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRD_W-1:0] major_len,
  input  logic [DIV_W-1:0] minor_len,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;
  logic [PRD_W-1:0] main_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      main_q <= '0;
      tick   <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pre_q >= minor_len) begin
        pre_q <= '0;
        if (main_q >= major_len) begin
          main_q <= '0;
          tick   <= 1'b1;
        end else begin
          main_q <= main_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qdac_sine_rom.sv
module qdac_sine_rom
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic [TBL_AW-1:0] addr,
  output logic [SAMPLE_W-1:0] data
);
  function automatic logic [SAMPLE_W-1:0] entry(input logic [TBL_AW-1:0] a);
    case (int'(a))
      0:  return 10'd512;   1:  return 10'd612;   2:  return 10'd708;   3:  return 10'd796;
      4:  return 10'd873;   5:  return 10'd937;   6:  return 10'd984;   7:  return 10'd1013;
      8:  return 10'd1023;  9:  return 10'd1013;  10: return 10'd984;   11: return 10'd937;
      12: return 10'd873;   13: return 10'd796;   14: return 10'd708;   15: return 10'd612;
      16: return 10'd512;   17: return 10'd412;   18: return 10'd316;   19: return 10'd228;
      20: return 10'd151;   21: return 10'd87;    22: return 10'd40;    23: return 10'd11;
      24: return 10'd1;     25: return 10'd11;    26: return 10'd40;    27: return 10'd87;
      28: return 10'd151;   29: return 10'd228;   30: return 10'd316;   default: return 10'd412;
    endcase
  endfunction

  // Registered read so the table maps onto a block ROM.
  always_ff @(posedge clk) begin
    data <= entry(addr);
  end
endmodule

// File: rtl/qdac_seq.sv
module qdac_seq
  import qdac_pkg::*;
#(
  parameter int PRD_W      = 16,
  parameter int DIV_W      = 8,
  parameter int SCLK_HALF  = 2,
  parameter int STROBE_CYC = 2,
  parameter int GAP_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRD_W-1:0] major_len,
  input  logic [DIV_W-1:0] minor_len,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             frm_n,
  output logic             sel_n,
  output logic             upd_n,
  output logic             busy
);
  localparam int MAX_A = (SCLK_HALF > STROBE_CYC) ? SCLK_HALF : STROBE_CYC;
  localparam int MAX_C = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int OFS_STEP = TBL_DEPTH / NUM_CH;

  logic                tick;
  seq_st_e             st;
  logic [CNT_W-1:0]    cnt;
  logic [BIT_W-1:0]    bits_left;
  logic [SLOT_W-1:0]   slot;
  logic                last_q, pend_q;
  logic [TBL_AW-1:0]   ptr;
  logic [WORD_W-1:0]   shreg, word_nx;
  logic [TBL_AW-1:0]   rd_addr;
  logic [SAMPLE_W-1:0] sample;
  logic                sclk_q, sdo_q, frm_q, sel_q, upd_q;

  qdac_tick #(.PRD_W(PRD_W), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .major_len(major_len), .minor_len(minor_len), .tick(tick)
  );

  assign rd_addr = ptr + TBL_AW'(int'(slot) * OFS_STEP);

  qdac_sine_rom u_rom (.clk(clk), .addr(rd_addr), .data(sample));

  assign word_nx = make_word(slot, sample);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  cnt <= '0;  bits_left <= '0;  slot <= '0;
      last_q <= 1'b0; pend_q <= 1'b0; ptr <= '0; shreg <= '0;
      sclk_q <= 1'b0; sdo_q <= 1'b0; frm_q <= 1'b1; sel_q <= 1'b1; upd_q <= 1'b1;
    end else begin
      if (tick && st != ST_IDLE) pend_q <= 1'b1;
      case (st)
        ST_IDLE: if (tick || pend_q) begin
          st <= ST_STROBE;  pend_q <= 1'b0;  upd_q <= 1'b0;
          cnt <= CNT_W'(STROBE_CYC - 1);
        end
        ST_STROBE: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            st <= ST_SETUP;  upd_q <= 1'b1;  sel_q <= 1'b0;
          end
        ST_SETUP: begin
          st <= ST_SHIFT;  frm_q <= 1'b0;  sclk_q <= 1'b1;
          sdo_q <= word_nx[WORD_W-1];  shreg <= {word_nx[WORD_W-2:0], 1'b0};
          bits_left <= BIT_W'(WORD_W - 1);  cnt <= CNT_W'(SCLK_HALF - 1);
        end
        ST_SHIFT: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            cnt <= CNT_W'(SCLK_HALF - 1);
            if (sclk_q) sclk_q <= 1'b0;
            else if (bits_left == '0) begin
              st <= ST_GAP;  frm_q <= 1'b1;  sdo_q <= 1'b0;
              cnt <= CNT_W'(GAP_CYC - 1);
              last_q <= (slot == SLOT_W'(NUM_CH - 1));
              slot <= slot + 1'b1;
            end else begin
              sclk_q <= 1'b1;  sdo_q <= shreg[WORD_W-1];
              shreg <= {shreg[WORD_W-2:0], 1'b0};  bits_left <= bits_left - 1'b1;
            end
          end
        ST_GAP: if (cnt != '0) cnt <= cnt - 1'b1;
          else if (last_q) begin
            st <= ST_IDLE;  sel_q <= 1'b1;  ptr <= ptr + 1'b1;  last_q <= 1'b0;
          end else begin
            st <= ST_SHIFT;  frm_q <= 1'b0;  sclk_q <= 1'b1;
            sdo_q <= word_nx[WORD_W-1];  shreg <= {word_nx[WORD_W-2:0], 1'b0};
            bits_left <= BIT_W'(WORD_W - 1);  cnt <= CNT_W'(SCLK_HALF - 1);
          end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk = sclk_q;
  assign ser_dat = sdo_q;
  assign frm_n   = frm_q;
  assign sel_n   = sel_q;
  assign upd_n   = upd_q;
  assign busy    = (st != ST_IDLE);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !upd_q |-> sel_q);
  // R3
  select_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst) $fell(sel_q) |-> $rose(upd_q));
  // R6
  frame_in_select_chk: assert property (@(posedge clk) disable iff (rst) !frm_q |-> !sel_q);
  // R6
  clock_in_frame_chk: assert property (@(posedge clk) disable iff (rst) sclk_q |-> !frm_q);
  // R7
  data_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo_q) |-> ($rose(sclk_q) || $rose(frm_q)));
  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> ($rose(sel_q) && ptr == TBL_AW'($past(ptr) + 1'b1)));
  // R10
  pending_served_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && st == ST_IDLE) |=> (st == ST_STROBE));
endmodule

// File: tb/sim_qdac_seq.sv
`timescale 1ns/1ps
module sim_qdac_seq;
  localparam int H = 2, STB = 2, GAP = 4;
  localparam int WORD = 32 * H;
  localparam int L = STB + 1 + 4 * (WORD + GAP);

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] major_len = '0;
  logic [7:0]  minor_len = '0;
  logic ser_clk, ser_dat, frm_n, sel_n, upd_n, busy;

  always #2.5 clk = ~clk;

  qdac_seq #(.PRD_W(16), .DIV_W(8), .SCLK_HALF(H), .STROBE_CYC(STB), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst(rst), .major_len(major_len), .minor_len(minor_len),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .frm_n(frm_n), .sel_n(sel_n), .upd_n(upd_n), .busy(busy)
  );

  int nchk = 0, nfail = 0;
  int sine_ref[32];
  int P = 1;
  bit cmp_en = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint a, input longint e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  function automatic int ref_word(input int w, input int p);
    int ch;
    ch = (w == 0) ? 0 : (w == 1) ? 2 : (w == 2) ? 1 : 3;
    return ch * 16384 + 4096 + sine_ref[(p + 8 * w) % 32] * 4;
  endfunction

  // Behavioural model: edge counter, activity window, pending flag, pointer.
  int k = 0, t = 0, ptr_m = 0;
  bit act = 0, pend = 0;
  bit e_upd = 1, e_sel = 1, e_frm = 1, e_clk = 0, e_dat = 0, e_busy = 0;

  always @(posedge clk) begin
    bit tin;
    if (rst) begin
      k = 0; t = 0; act = 0; pend = 0; ptr_m = 0;
    end else begin
      k++;
      tin = (k - 1 >= P) && ((k - 1) % P == 0);
      if (act) begin
        t++;
        if (tin) pend = 1;
        if (t == L) begin act = 0; ptr_m = (ptr_m + 1) % 32; end
      end else if (tin || pend) begin
        act = 1; t = 0; pend = 0;
      end
    end
    e_upd = 1; e_sel = 1; e_frm = 1; e_clk = 0; e_dat = 0; e_busy = act;
    if (act) begin
      if (t < STB) e_upd = 0;
      else begin
        int u;
        e_sel = 0;
        u = t - STB - 1;
        if (u >= 0) begin
          int w, r, b;
          w = u / (WORD + GAP);
          r = u % (WORD + GAP);
          if (r < WORD) begin
            e_frm = 0;
            b = r / (2 * H);
            e_clk = (r % (2 * H)) < H;
            e_dat = ((ref_word(w, ptr_m) >> (15 - b)) & 1) != 0;
          end
        end
      end
    end
  end

  // Frame / edge monitor state
  bit prev_upd = 1, prev_sel = 1, prev_clk = 0, prev_frm = 1, seen_start = 0;
  int last_start = 0, sel_fall = 0, hi_run = 0, nbits = 0, fidx = 0;
  int cap = 0;

  always @(negedge clk) if (cmp_en) begin
    // per-clock comparison against the model
    chk(upd_n === e_upd, "R3", "upd_n", upd_n, e_upd);
    chk(sel_n === e_sel, "R4", "sel_n", sel_n, e_sel);
    chk(frm_n === e_frm, "R6", "frm_n", frm_n, e_frm);
    chk(ser_clk === e_clk, "R7", "ser_clk", ser_clk, e_clk);
    chk(ser_dat === e_dat, "R5", "ser_dat", ser_dat, e_dat);
    chk(busy === e_busy, "R10", "busy", busy, e_busy);
    if (!rst) begin
      if (!upd_n && prev_upd) begin
        if (!seen_start) chk(k == P + 1, "R2", "first strobe edge", k, P + 1);
        else if (P < L + 1) chk(k - last_start == L + 1, "R10", "held-tick restart spacing", k - last_start, L + 1);
        else chk(k - last_start == P, "R2", "strobe spacing", k - last_start, P);
        seen_start = 1; last_start = k;
      end
      if (upd_n && !prev_upd) chk(k - last_start == STB, "R3", "strobe width", k - last_start, STB);
      if (!sel_n && prev_sel) sel_fall = k;
      if (sel_n && !prev_sel) chk(k - sel_fall == L - STB, "R4", "select width", k - sel_fall, L - STB);
      if (ser_clk) hi_run++;
      else if (prev_clk) begin
        chk(hi_run == H, "R7", "clock high run", hi_run, H);
        hi_run = 0;
        if (!frm_n) begin cap = ((cap << 1) | int'(ser_dat)) & 16'hFFFF; nbits++; end
      end
      if (frm_n && !prev_frm) begin
        int w, sq, nib, smp;
        w = fidx % 4; sq = fidx / 4;
        nib = (w == 0) ? 1 : (w == 1) ? 9 : (w == 2) ? 5 : 13;
        smp = sine_ref[(sq % 32 + 8 * w) % 32];
        chk(nbits == 16, "R6", "bits per frame", nbits, 16);
        chk(((cap >> 12) & 15) == nib, "R5", "address/control nibble", (cap >> 12) & 15, nib);
        chk((cap & 3) == 0, "R5", "low pad bits", cap & 3, 0);
        if (sq >= 32) chk(((cap >> 2) & 1023) == smp, "R9", "sample after pointer wrap", (cap >> 2) & 1023, smp);
        else chk(((cap >> 2) & 1023) == smp, "R8", "sample at phase offset", (cap >> 2) & 1023, smp);
        fidx++; nbits = 0; cap = 0;
      end
    end
    prev_upd = upd_n; prev_sel = sel_n; prev_clk = ser_clk; prev_frm = frm_n;
  end

  task automatic run_cfg(input int maj, input int mnr, input int cycles, input bit check_idle);
    @(negedge clk); #1;
    rst = 1;
    major_len = 16'(maj); minor_len = 8'(mnr);
    P = (maj + 1) * (mnr + 1);
    prev_upd = 1; prev_sel = 1; prev_clk = 0; prev_frm = 1; seen_start = 0;
    last_start = 0; sel_fall = 0; hi_run = 0; nbits = 0; fidx = 0; cap = 0;
    repeat (5) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    if (check_idle) begin
      // R1: idle levels after reset release, before the first expiry
      chk(upd_n === 1'b1 && sel_n === 1'b1 && frm_n === 1'b1, "R1", "strobe/select/frame idle",
          {upd_n, sel_n, frm_n}, 7);
      chk(ser_clk === 1'b0 && ser_dat === 1'b0 && busy === 1'b0, "R1", "clock/data/busy idle",
          {ser_clk, ser_dat, busy}, 0);
    end
    repeat (cycles) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      sine_ref[i] = $rtoi($floor(512.0 + 511.0 * $sin(2.0 * 3.14159265358979 * i / 32.0) + 0.5));
    @(posedge clk); #1;
    cmp_en = 1;
    run_cfg(23, 11, 33 * 288 + 400, 1);  // idle between sequences, pointer wraps (R9)
    run_cfg(9, 9, 3000, 0);              // period shorter than a sequence: held ticks (R10)
    run_cfg(0, 0, 1500, 0);              // expiry every clock
    run_cfg(279, 0, 1500, 0);            // period just above sequence length
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule